// File: doc/BRIEF.md
# 8-Bit Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle the sequencer may present an operation code, the accumulator value, a second operand, the current five status flags and, for the wide add, two 16-bit register-pair values. One clock later the block returns a registered result byte, a registered flag vector, a 16-bit pair result and two write enables. The enables tell the register file whether the accumulator or the HL pair must take the new value.

Each operation class follows its own flag rule. Binary arithmetic rewrites every flag. Compare computes a difference only to set flags and writes nothing back. Logic operations rewrite sign, zero and parity and force the two carries to fixed values. Rotates and the carry-only operations touch nothing but carry. Decimal adjust corrects a packed-BCD sum. The 16-bit pair add touches carry alone. Register storage and memory access stay outside the block.

Top module: `alu8_unit`

## Requirements
- R1: The flag vector is laid out as bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry. Outputs are registered one cycle after `in_valid`, and `out_valid` is high in exactly that cycle. During reset `out_valid`, `acc_we`, `hl_we`, `result` and `flags_out` are all zero.
- R2: ADD (code 0) and ADC (code 1, which adds the incoming carry) return A+B (+CY) and rewrite all flags. Sign is result bit 7, zero is set for a zero result, AC is the carry out of bit 3, CY is the carry out of bit 7, and parity is 1 for an even count of one bits.
- R3: SUB (code 2) and SBB (code 3, which also subtracts CY) return A−B (−CY) and rewrite all flags. CY is set when B plus the incoming borrow exceeds A as unsigned values, and AC is the borrow out of bit 3.
- R4: CMP (code 4) sets flags exactly as SUB does, does not assert `acc_we`, and returns A unchanged on `result`.
- R5: AND (code 5) rewrites S, Z and P, sets AC and clears CY. XOR (code 6) and OR (code 7) rewrite S, Z and P and clear both AC and CY.
- R6: INC (code 8) and DEC (code 9) act on A, rewrite S, Z, AC and P (AC is the carry into or the borrow out of bit 4), and leave CY unchanged.
- R7: RLC (code 10) moves bit 7 to bit 0 and to CY. RRC (code 11) moves bit 0 to bit 7 and to CY. All other flags stay unchanged.
- R8: RAL (code 12) shifts left with the old CY entering bit 0 and bit 7 leaving into CY. RAR (code 13) shifts right with the old CY entering bit 7 and bit 0 leaving into CY. All other flags stay unchanged.
- R9: CMA (code 14) returns the complement of A and keeps every flag. STC (code 15) forces CY to 1. CMC (code 16) inverts CY. STC and CMC keep the other flags and do not write A.
- R10: DAA (code 17) adds 6 when the low nibble exceeds 9 or AC is set. It then adds 0x60 when the resulting high nibble exceeds 9, when CY is set, or when the first step carried out of bit 7. CY becomes 1 exactly when that second correction is applied. AC becomes the carry out of bit 3 from the first step. S, Z and P follow the result.
- R11: DAD (code 18) returns `hl_in + pair_in` on `hl_out` and asserts `hl_we` but not `acc_we`. CY is the carry out of bit 15, and the other four flags stay unchanged.
- R12: `acc_we` is asserted for codes 0–3, 5–14 and 17. Codes 19–31 assert no enable, keep all flags and return A on `result`. `acc_we` and `hl_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator value A |
| opnd_in | input | 8 | Second operand B |
| flags_in | input | 5 | Current flags {S,Z,AC,P,CY} |
| pair_in | input | 16 | Register pair added by DAD |
| hl_in | input | 16 | HL pair value |
| out_valid | output | 1 | Registered result is present |
| result | output | 8 | Result byte |
| flags_out | output | 5 | New flags {S,Z,AC,P,CY} |
| hl_out | output | 16 | Pair result (HL passed through for other codes) |
| acc_we | output | 1 | Accumulator must be written |
| hl_we | output | 1 | HL pair must be written |

## Verification
Some properties are checked on every cycle. These are the one-cycle valid timing, the mutual exclusion of the two enables, and sign, zero and parity agreeing with any written result. They also cover the preserved flags for rotates, CMA and DAD, the untouched carry of INC and DEC, and the unwritten accumulator of CMP. Other behaviour only shows up in the bench's scenarios. That includes the actual carry and borrow values, the borrow-out-of-nibble rule, the two-step decimal correction with its carry ripple, the 16-bit overflow and the fate of unassigned codes. The bench checks these against an integer reference model over directed corner cases and a random sweep of all 32 codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int PW  = 2 * DW;
  localparam int OPW = 5;
  localparam int FW  = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_XOR = 5'd6,  OP_OR  = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_STC = 5'd15,
    OP_CMC = 5'd16, OP_DAA = 5'd17, OP_DAD = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic logic even_par(input logic [DW-1:0] v);
    return ~^v;
  endfunction

  function automatic logic [DW:0] add_w(input logic [DW-1:0] a,
                                        input logic [DW-1:0] b,
                                        input logic cin);
    return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
  endfunction

  function automatic logic nib_carry(input logic [NW-1:0] a,
                                     input logic [NW-1:0] b,
                                     input logic cin);
    logic [NW:0] t;
    t = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, cin};
    return t[NW];
  endfunction

  function automatic flags_t with_szp(input logic [DW-1:0] r, input flags_t f);
    flags_t o;
    o   = f;
    o.s = r[DW-1];
    o.z = (r == '0);
    o.p = even_par(r);
    return o;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  flags_t         fi,
  output logic [DW-1:0]  r,
  output flags_t         fo
);

  logic [DW-1:0] opb;
  logic          cin;
  logic          invert;
  logic          keep_cy;
  logic [DW:0]   sum;
  logic          carry7;
  logic          carry3;

  always_comb begin
    opb     = b;
    cin     = 1'b0;
    invert  = 1'b0;
    keep_cy = 1'b0;
    case (op)
      OP_ADC: cin = fi.cy;
      OP_SUB, OP_CMP: begin
        opb = ~b; cin = 1'b1; invert = 1'b1;
      end
      OP_SBB: begin
        opb = ~b; cin = ~fi.cy; invert = 1'b1;
      end
      OP_INC: begin
        opb = '0; cin = 1'b1; keep_cy = 1'b1;
      end
      OP_DEC: begin
        opb = '1; cin = 1'b0; invert = 1'b1; keep_cy = 1'b1;
      end
      default: ;
    endcase
  end

  assign sum    = add_w(a, opb, cin);
  assign carry7 = sum[DW];
  assign carry3 = nib_carry(a[NW-1:0], opb[NW-1:0], cin);

  always_comb begin
    r     = sum[DW-1:0];
    fo    = with_szp(r, fi);
    fo.ac = carry3 ^ invert;
    fo.cy = keep_cy ? fi.cy : (carry7 ^ invert);
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [DW-1:0]  b,
  input  flags_t         fi,
  output logic [DW-1:0]  r,
  output flags_t         fo
);

  always_comb begin
    r  = a;
    fo = fi;
    case (op)
      OP_AND: begin
        r = a & b; fo = with_szp(r, fi); fo.ac = 1'b1; fo.cy = 1'b0;
      end
      OP_XOR: begin
        r = a ^ b; fo = with_szp(r, fi); fo.ac = 1'b0; fo.cy = 1'b0;
      end
      OP_OR: begin
        r = a | b; fo = with_szp(r, fi); fo.ac = 1'b0; fo.cy = 1'b0;
      end
      OP_RLC: begin
        r = {a[DW-2:0], a[DW-1]}; fo.cy = a[DW-1];
      end
      OP_RRC: begin
        r = {a[0], a[DW-1:1]}; fo.cy = a[0];
      end
      OP_RAL: begin
        r = {a[DW-2:0], fi.cy}; fo.cy = a[DW-1];
      end
      OP_RAR: begin
        r = {fi.cy, a[DW-1:1]}; fo.cy = a[0];
      end
      OP_CMA: r = ~a;
      OP_STC: fo.cy = 1'b1;
      OP_CMC: fo.cy = ~fi.cy;
      default: ;
    endcase
  end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  flags_t        fi,
  output logic [DW-1:0] r,
  output flags_t        fo
);

  localparam logic [NW-1:0] NIB_MAX = NW'(9);
  localparam logic [DW:0]   LO_FIX  = (DW+1)'(6);
  localparam logic [DW-1:0] HI_FIX  = DW'(6) << NW;

  logic          fix_lo;
  logic          fix_hi;
  logic [DW:0]   step1;

  assign fix_lo = (a[NW-1:0] > NIB_MAX) | fi.ac;
  assign step1  = {1'b0, a} + (fix_lo ? LO_FIX : '0);
  assign fix_hi = (step1[DW-1:NW] > NIB_MAX) | fi.cy | step1[DW];

  always_comb begin
    r     = step1[DW-1:0] + (fix_hi ? HI_FIX : '0);
    fo    = with_szp(r, fi);
    fo.ac = (a[NW-1:0] > NIB_MAX);
    fo.cy = fix_hi;
  end

endmodule

// File: rtl/alu8_pairadd.sv
module alu8_pairadd #(
  parameter int PAIR_W = 16
) (
  input  logic [PAIR_W-1:0] hl,
  input  logic [PAIR_W-1:0] pr,
  output logic [PAIR_W-1:0] sum,
  output logic              cy
);

  logic [PAIR_W:0] wide;

  assign wide = {1'b0, hl} + {1'b0, pr};
  assign sum  = wide[PAIR_W-1:0];
  assign cy   = wide[PAIR_W];

endmodule

// File: rtl/alu8_unit.sv
module alu8_unit
  import alu8_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [alu8_pkg::OPW-1:0]    op,
  input  logic [alu8_pkg::DW-1:0]     acc_in,
  input  logic [alu8_pkg::DW-1:0]     opnd_in,
  input  logic [alu8_pkg::FW-1:0]     flags_in,
  input  logic [alu8_pkg::PW-1:0]     pair_in,
  input  logic [alu8_pkg::PW-1:0]     hl_in,
  output logic                        out_valid,
  output logic [alu8_pkg::DW-1:0]     result,
  output logic [alu8_pkg::FW-1:0]     flags_out,
  output logic [alu8_pkg::PW-1:0]     hl_out,
  output logic                        acc_we,
  output logic                        hl_we
);

  flags_t fi;
  assign fi = flags_t'(flags_in);

  // operation class decode, brought out for the checks
  logic cls_arith, cls_bits, cls_daa, cls_dad;
  logic is_rot, is_incdec, is_cmp, is_cma;
  logic writes_acc, szp_from_res;

  assign cls_arith = (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP,
                                 OP_INC, OP_DEC});
  assign cls_bits  = (op inside {OP_AND, OP_XOR, OP_OR, OP_RLC, OP_RRC,
                                 OP_RAL, OP_RAR, OP_CMA, OP_STC, OP_CMC});
  assign cls_daa   = (op == OP_DAA);
  assign cls_dad   = (op == OP_DAD);
  assign is_rot    = (op inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR});
  assign is_incdec = (op inside {OP_INC, OP_DEC});
  assign is_cmp    = (op == OP_CMP);
  assign is_cma    = (op == OP_CMA);
  assign writes_acc = (cls_arith & ~is_cmp) | cls_daa |
                      (cls_bits & ~(op inside {OP_STC, OP_CMC}));
  assign szp_from_res = (cls_arith & ~is_cmp) | cls_daa |
                        (op inside {OP_AND, OP_XOR, OP_OR});

  logic [DW-1:0] r_as, r_bo, r_da;
  flags_t        f_as, f_bo, f_da;
  logic [PW-1:0] hl_sum;
  logic          hl_cy;

  alu8_addsub u_addsub (
    .op (op), .a (acc_in), .b (opnd_in), .fi (fi), .r (r_as), .fo (f_as)
  );

  alu8_bitops u_bitops (
    .op (op), .a (acc_in), .b (opnd_in), .fi (fi), .r (r_bo), .fo (f_bo)
  );

  alu8_decadj u_decadj (
    .a (acc_in), .fi (fi), .r (r_da), .fo (f_da)
  );

  alu8_pairadd #(.PAIR_W (PW)) u_pairadd (
    .hl (hl_in), .pr (pair_in), .sum (hl_sum), .cy (hl_cy)
  );

  logic [DW-1:0] nxt_res;
  flags_t        nxt_fl;
  logic [PW-1:0] nxt_hl;

  always_comb begin
    nxt_res = acc_in;
    nxt_fl  = fi;
    nxt_hl  = hl_in;
    if (cls_arith) begin
      nxt_res = is_cmp ? acc_in : r_as;
      nxt_fl  = f_as;
    end else if (cls_bits) begin
      nxt_res = r_bo;
      nxt_fl  = f_bo;
    end else if (cls_daa) begin
      nxt_res = r_da;
      nxt_fl  = f_da;
    end else if (cls_dad) begin
      nxt_hl    = hl_sum;
      nxt_fl.cy = hl_cy;
    end
  end

  logic szp_res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= '0;
      hl_out    <= '0;
      acc_we    <= 1'b0;
      hl_we     <= 1'b0;
      szp_res_q <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= nxt_res;
        flags_out <= nxt_fl;
        hl_out    <= nxt_hl;
        acc_we    <= writes_acc;
        hl_we     <= cls_dad;
        szp_res_q <= szp_from_res;
      end else begin
        acc_we    <= 1'b0;
        hl_we     <= 1'b0;
        szp_res_q <= 1'b0;
      end
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R12
  we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_we, hl_we}) && ((acc_we || hl_we) -> out_valid));

  // R2
  szp_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    szp_res_q |-> (flags_out[4] == result[DW-1]) &&
                  (flags_out[3] == (result == '0)) &&
                  (flags_out[1] == ~^result));

  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cmp) |=> (!acc_we && result == $past(acc_in)));

  // R6
  incdec_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_incdec) |=> (flags_out[0] == $past(flags_in[0])));

  // R7
  rot_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_rot) |=> (flags_out[4:1] == $past(flags_in[4:1])));

  // R9
  cma_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_cma) |=> (flags_out == $past(flags_in) &&
                              result == ~$past(acc_in)));

  // R11
  dad_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cls_dad) |=> (hl_we && flags_out[4:1] == $past(flags_in[4:1])));

endmodule

// File: tb/test_alu8_unit.sv
module test_alu8_unit;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  acc_in = '0, opnd_in = '0;
  logic [4:0]  flags_in = '0;
  logic [15:0] pair_in = '0, hl_in = '0;
  logic        out_valid;
  logic [7:0]  result;
  logic [4:0]  flags_out;
  logic [15:0] hl_out;
  logic        acc_we, hl_we;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_unit i_alu8_unit (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op (op),
    .acc_in (acc_in), .opnd_in (opnd_in), .flags_in (flags_in),
    .pair_in (pair_in), .hl_in (hl_in), .out_valid (out_valid),
    .result (result), .flags_out (flags_out), .hl_out (hl_out),
    .acc_we (acc_we), .hl_we (hl_we)
  );

  typedef struct {
    logic [7:0]  res;
    logic [4:0]  fl;
    logic [15:0] hl;
    logic        awe;
    logic        hwe;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   tests = 0;
  int   fails = 0;
  bit   done  = 1'b0;

  function automatic logic par_even(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  function automatic exp_t model(input int o, input int a, input int b,
                                 input logic [4:0] f, input int pr, input int hl);
    exp_t e;
    int   v;
    int   lo;
    logic s, z, ac, p, cy, upd;
    {s, z, ac, p, cy} = f;
    v = a; upd = 1'b0;
    e.awe = 1'b0; e.hwe = 1'b0; e.hl = hl[15:0];
    case (o)
      0, 1: begin
        v  = a + b + ((o == 1) ? int'(cy) : 0);
        ac = ((a % 16) + (b % 16) + ((o == 1) ? int'(cy) : 0)) > 15;
        cy = v > 255; upd = 1'b1; e.awe = 1'b1;
      end
      2, 3, 4: begin
        v  = a - b - ((o == 3) ? int'(cy) : 0);
        ac = ((a % 16) - (b % 16) - ((o == 3) ? int'(cy) : 0)) < 0;
        cy = v < 0; upd = 1'b1; e.awe = (o != 4);
      end
      5: begin v = a & b; ac = 1; cy = 0; upd = 1'b1; e.awe = 1'b1; end
      6: begin v = a ^ b; ac = 0; cy = 0; upd = 1'b1; e.awe = 1'b1; end
      7: begin v = a | b; ac = 0; cy = 0; upd = 1'b1; e.awe = 1'b1; end
      8: begin v = a + 1; ac = (a % 16) == 15; upd = 1'b1; e.awe = 1'b1; end
      9: begin v = a - 1; ac = (a % 16) == 0;  upd = 1'b1; e.awe = 1'b1; end
      10: begin v = (a * 2) % 256 + a / 128; cy = a >= 128; e.awe = 1'b1; end
      11: begin v = a / 2 + (a % 2) * 128; cy = (a % 2) == 1; e.awe = 1'b1; end
      12: begin v = (a * 2) % 256 + int'(cy); cy = a >= 128; e.awe = 1'b1; end
      13: begin v = a / 2 + int'(cy) * 128; cy = (a % 2) == 1; e.awe = 1'b1; end
      14: begin v = 255 - a; e.awe = 1'b1; end
      15: cy = 1'b1;
      16: cy = ~cy;
      17: begin
        lo = a % 16;
        if (lo > 9 || ac) v = v + 6;
        ac = lo > 9;
        if (((v / 16) % 16) > 9 || cy || v > 255) begin v = v + 96; cy = 1'b1; end
        else cy = 1'b0;
        upd = 1'b1; e.awe = 1'b1;
      end
      18: begin
        v = hl + pr; cy = v > 65535; e.hl = v[15:0]; v = a; e.hwe = 1'b1;
      end
      default: ;
    endcase
    if (o == 4) e.res = a[7:0];
    else e.res = v[7:0];
    if (upd) begin
      s = v[7]; z = (v % 256) == 0; p = par_even(v % 256);
    end
    e.fl = {s, z, ac, p, cy};
    return e;
  endfunction

  task automatic drive(input int o, input int a, input int b, input logic [4:0] f,
                       input int pr, input int hl, input string tag);
    exp_t e;
    @(negedge clk);
    op = o[4:0]; acc_in = a[7:0]; opnd_in = b[7:0]; flags_in = f;
    pair_in = pr[15:0]; hl_in = hl[15:0]; in_valid = 1'b1;
    e = model(o % 32, a % 256, b % 256, f, pr % 65536, hl % 65536);
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        tests++;
        if (sbq.size() == 0) begin
          fails++;
          $display("FAIL R1: out_valid with no pending op (actual 1, expected 0)");
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (result !== e.res || flags_out !== e.fl || hl_out !== e.hl ||
              acc_we !== e.awe || hl_we !== e.hwe) begin
            fails++;
            $display("FAIL %s: actual res=%h fl=%b hl=%h awe=%b hwe=%b expected res=%h fl=%b hl=%h awe=%b hwe=%b",
                     e.tag, result, flags_out, hl_out, acc_we, hl_we,
                     e.res, e.fl, e.hl, e.awe, e.hwe);
          end
        end
      end else if (acc_we || hl_we) begin
        tests++; fails++;
        $display("FAIL R12: enable without out_valid (actual %b%b, expected 00)", acc_we, hl_we);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    tests++;
    if (out_valid !== 1'b0 || acc_we !== 1'b0 || hl_we !== 1'b0 ||
        result !== 8'h00 || flags_out !== 5'b0) begin
      fails++;
      $display("FAIL R1: reset state actual v=%b r=%h f=%b expected all zero",
               out_valid, result, flags_out);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 add family
    drive(0, 8'h3A, 8'hC6, 5'b00000, 0, 0, "R2 add to zero with carries");
    drive(0, 8'h12, 8'h34, 5'b00001, 0, 0, "R2 add ignores cy");
    drive(1, 8'h7F, 8'h00, 5'b00001, 0, 0, "R2 adc overflow sign");
    drive(1, 8'hFF, 8'hFF, 5'b00001, 0, 0, "R2 adc max");
    // R3 subtract family
    drive(2, 8'h10, 8'h01, 5'b00000, 0, 0, "R3 sub nibble borrow");
    drive(2, 8'h05, 8'h07, 5'b00000, 0, 0, "R3 sub borrow");
    drive(3, 8'h05, 8'h05, 5'b00001, 0, 0, "R3 sbb borrow in");
    drive(3, 8'h40, 8'h0F, 5'b00000, 0, 0, "R3 sbb no borrow in");
    // R4 compare
    drive(4, 8'h20, 8'h30, 5'b00000, 0, 0, "R4 cmp less");
    drive(4, 8'h55, 8'h55, 5'b00001, 0, 0, "R4 cmp equal");
    drive(4, 8'h90, 8'h10, 5'b11111, 0, 0, "R4 cmp greater");
    // R5 logic
    drive(5, 8'hF0, 8'h3C, 5'b00001, 0, 0, "R5 and");
    drive(6, 8'hAA, 8'hAA, 5'b00101, 0, 0, "R5 xor to zero");
    drive(7, 8'h81, 8'h02, 5'b00101, 0, 0, "R5 or");
    // R6 inc/dec
    drive(8, 8'hFF, 0, 5'b00000, 0, 0, "R6 inc wrap cy kept 0");
    drive(8, 8'h0F, 0, 5'b00001, 0, 0, "R6 inc nibble cy kept 1");
    drive(9, 8'h00, 0, 5'b00000, 0, 0, "R6 dec wrap cy kept");
    drive(9, 8'h01, 0, 5'b11101, 0, 0, "R6 dec to zero");
    // R7 / R8 rotates
    drive(10, 8'h81, 0, 5'b11110, 0, 0, "R7 rlc");
    drive(11, 8'h01, 0, 5'b11110, 0, 0, "R7 rrc");
    drive(12, 8'h80, 0, 5'b00001, 0, 0, "R8 ral");
    drive(13, 8'h02, 0, 5'b00001, 0, 0, "R8 rar");
    // R9 carry ops and complement
    drive(14, 8'h5A, 0, 5'b10101, 0, 0, "R9 cma");
    drive(15, 8'h33, 0, 5'b01010, 0, 0, "R9 stc");
    drive(16, 8'h33, 0, 5'b01011, 0, 0, "R9 cmc");
    // R10 decimal adjust
    drive(17, 8'h9A, 0, 5'b00000, 0, 0, "R10 daa both nibbles");
    drive(17, 8'h11, 0, 5'b00100, 0, 0, "R10 daa ac only");
    drive(17, 8'h72, 0, 5'b00001, 0, 0, "R10 daa cy only");
    drive(17, 8'hFA, 0, 5'b00000, 0, 0, "R10 daa ripple carry");
    // R11 pair add
    drive(18, 8'h44, 0, 5'b11110, 16'h8001, 16'h8000, "R11 dad overflow");
    drive(18, 8'h44, 0, 5'b00001, 16'h1234, 16'h0101, "R11 dad no overflow");
    // R12 unassigned codes
    drive(19, 8'hC3, 8'h11, 5'b10110, 16'h1111, 16'h2222, "R12 code 19 inert");
    drive(31, 8'h07, 8'hFF, 5'b01001, 16'hFFFF, 16'h0001, "R12 code 31 inert");
    idle();
    idle();
    // R12 random sweep over all codes
    for (int k = 0; k < 400; k++) begin
      drive(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), 5'($urandom_range(0, 31)),
            int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
            "R12 random sweep");
      if (k % 7 == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    tests++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d results missing (expected 0)", sbq.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule